// File: doc/BRIEF.md
# Address-Space TLB Flush Engine

This block removes the translations that belong to one address space from a pair of translation lookaside buffers. One buffer holds instruction translations and the other holds data translations. Each has four ways of sixteen entries. A start pulse carries an address-space ID. The engine then reads every one of the 128 entries in turn. It invalidates each entry that is valid, not marked global and tagged with that ID. Global mappings and the mappings of other address spaces are left as they are.

The entry storage sits outside the block and is reached through a simple memory port. Each entry is a pair of 32-bit words. The high word holds the virtual page number in bits [31:13] and the ID tag in bits [7:0]. The low word holds the global flag in bit 4 and the valid flag in bit 3. Reads return data one cycle after the read strobe. Only the low word is ever written back.

For every entry it invalidates, the engine also puts out the page's virtual address with a strobe, so that caches further down the line can drop their copies. While the walk runs, `busy_o` is high. A single-cycle `done_o` pulse marks the end of the walk.

Top module: `tlb_asid_flush`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mem_rd_o`, `mem_wr_o` and `inv_valid_o` are all low. They stay low, apart from the one-cycle `done_o` pulse, whenever no walk is running.
- R2: While idle, a high `start_i` starts a walk and captures `asid_i[7:0]` as the flush ID. Bits [31:8] of `asid_i` have no effect on which entries are flushed.
- R3: The walk visits every entry of both buffers exactly once. The order is buffer (instruction first), then way, then index. The entry address is `{buffer, way[1:0], index[3:0]}`, from 0 up to 127. Each entry takes two cycles: a read cycle with `mem_rd_o` high, then a check cycle. `busy_o` is therefore high for exactly 256 cycles.
- R4: In the check cycle, the engine takes `mem_rdata_lo_i` and `mem_rdata_hi_i` to be the words read in the preceding cycle. `mem_addr_o` keeps the same value across both cycles.
- R5: An entry is flushed only when all three of these hold: low-word bit 3 is 1, low-word bit 4 is 0, and high-word bits [7:0] equal the flush ID. No other entry is written.
- R6: A flush writes the entry's low word back in the check cycle, at the same address, with bit 3 cleared and every other bit unchanged.
- R7: In the same cycle as each flush write, `inv_valid_o` is high for one cycle. `inv_vaddr_o` then equals high-word bits [31:13] shifted left by 13, with the low 13 bits zero. The strobes come out in walk order.
- R8: `done_o` is high for exactly one cycle. That cycle is the one right after the check cycle of entry 127, and `busy_o` is already low in it.
- R9: A `start_i` pulse that arrives while a walk is running is ignored. The running walk keeps its flush ID and its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start a walk when the engine is idle |
| asid_i | input | 32 | Address-space ID; only bits [7:0] are used |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle pulse when the walk ends |
| mem_addr_o | output | 7 | Entry address {buffer, way, index} |
| mem_rd_o | output | 1 | Read strobe for the entry storage |
| mem_rdata_lo_i | input | 32 | Low word, valid one cycle after the read |
| mem_rdata_hi_i | input | 32 | High word, valid one cycle after the read |
| mem_wr_o | output | 1 | Write strobe for the low word |
| mem_wdata_lo_o | output | 32 | Low word to write |
| inv_valid_o | output | 1 | Strobe for each invalidated page |
| inv_vaddr_o | output | 32 | Virtual address of the invalidated page |

## Verification
The assertions assume that the entry storage behaves as a one-cycle-latency memory. In every check cycle, the read-data inputs must hold the entry addressed in the read cycle before it. On that assumption, each write can be traced back to an entry whose valid bit was set and whose global bit was clear. The bench meets this assumption with a behavioural memory that registers both words on the read strobe and applies writes on the same clock edge. Between walks, it reloads the memory from a fixed pattern, so that every case starts from a known state. Start pulses arrive at any time, including in the middle of a walk.

// File: rtl/tlb_asid_flush.sv
module tlb_asid_flush #(
  parameter int ID_W       = 8,
  parameter int TLB_N      = 2,
  parameter int WAY_N      = 4,
  parameter int IDX_N      = 16,
  parameter int PAGE_SHIFT = 13,
  parameter int VALID_BIT  = 3,
  parameter int GLOBAL_BIT = 4,
  localparam int ENT_N     = TLB_N * WAY_N * IDX_N,
  localparam int AW        = $clog2(ENT_N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [31:0]   asid_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  input  logic [31:0]   mem_rdata_lo_i,
  input  logic [31:0]   mem_rdata_hi_i,
  output logic          mem_wr_o,
  output logic [31:0]   mem_wdata_lo_o,
  output logic          inv_valid_o,
  output logic [31:0]   inv_vaddr_o
);

  localparam logic [AW-1:0] LAST     = AW'(ENT_N - 1);
  localparam logic [31:0]   ID_MASK  = (32'd1 << ID_W) - 32'd1;
  localparam logic [31:0]   PG_MASK  = ~((32'd1 << PAGE_SHIFT) - 32'd1);
  localparam logic [31:0]   VLD_MASK = 32'd1 << VALID_BIT;

  logic          busy_q, check_q, done_q;
  logic [AW-1:0] ptr_q;
  logic [31:0]   id_q;
  logic          hit;

  assign hit = busy_q && check_q
            && mem_rdata_lo_i[VALID_BIT] && !mem_rdata_lo_i[GLOBAL_BIT]
            && ((mem_rdata_hi_i & ID_MASK) == id_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      check_q <= 1'b0;
      done_q  <= 1'b0;
      ptr_q   <= '0;
      id_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          check_q <= 1'b0;
          ptr_q   <= '0;
          id_q    <= asid_i & ID_MASK;
        end
      end else if (!check_q) begin
        check_q <= 1'b1;
      end else begin
        check_q <= 1'b0;
        if (ptr_q == LAST) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
    end
  end

  assign busy_o         = busy_q;
  assign done_o         = done_q;
  assign mem_addr_o     = ptr_q;
  assign mem_rd_o       = busy_q && !check_q;
  assign mem_wr_o       = hit;
  assign mem_wdata_lo_o = mem_rdata_lo_i & ~VLD_MASK;
  assign inv_valid_o    = hit;
  assign inv_vaddr_o    = mem_rdata_hi_i & PG_MASK;

endmodule

// File: rtl/tlb_asid_flush_chk.sv
module tlb_asid_flush_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          done_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_rd_o,
  input logic [31:0]   mem_rdata_lo_i,
  input logic          mem_wr_o,
  input logic [31:0]   mem_wdata_lo_o,
  input logic          inv_valid_o,
  input logic [31:0]   inv_vaddr_o
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_rd_o && !mem_wr_o && !inv_valid_o));

  // R3
  read_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o);

  // R4
  write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> ($past(mem_rd_o) && $stable(mem_addr_o)));

  // R5
  flush_only_valid_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> (mem_rdata_lo_i[3] && !mem_rdata_lo_i[4]));

  // R6
  write_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> !mem_wdata_lo_o[3]);

  // R7
  strobe_page_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid_o |-> (mem_wr_o && inv_vaddr_o[12:0] == 13'd0));

  // R8
  done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

bind tlb_asid_flush tlb_asid_flush_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_tlb_asid_flush.sv
module sim_tlb_asid_flush;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] asid_i = '0;
  logic        busy_o, done_o, mem_rd_o, mem_wr_o, inv_valid_o;
  logic [6:0]  mem_addr_o;
  logic [31:0] mem_rdata_lo_i, mem_rdata_hi_i, mem_wdata_lo_o, inv_vaddr_o;

  always #5 clk = ~clk;

  tlb_asid_flush u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .asid_i(asid_i),
    .busy_o(busy_o), .done_o(done_o), .mem_addr_o(mem_addr_o),
    .mem_rd_o(mem_rd_o), .mem_rdata_lo_i(mem_rdata_lo_i),
    .mem_rdata_hi_i(mem_rdata_hi_i), .mem_wr_o(mem_wr_o),
    .mem_wdata_lo_o(mem_wdata_lo_o), .inv_valid_o(inv_valid_o),
    .inv_vaddr_o(inv_vaddr_o)
  );

  function automatic logic [7:0] gen_pid(int a);
    case (a % 4)
      0: return 8'h11;
      1: return 8'h22;
      2: return 8'h11;
      default: return 8'h33;
    endcase
  endfunction

  function automatic logic [31:0] gen_hi(int a);
    logic [18:0] vpn = 19'(a * 37 + 5);
    return {vpn, 5'h0A, gen_pid(a)};
  endfunction

  function automatic logic [31:0] gen_lo(int a);
    logic [18:0] pfn = 19'(a * 11 + 3);
    logic g = (a % 5) == 0;
    logic v = (a % 3) != 0;
    return {pfn, 8'h5A, g, v, 3'(a)};
  endfunction

  logic [31:0] lo_m [128];
  logic [31:0] hi_m [128];
  logic        load_req = 1'b0;

  always @(posedge clk) begin
    if (load_req) begin
      for (int a = 0; a < 128; a++) begin
        lo_m[a] <= gen_lo(a);
        hi_m[a] <= gen_hi(a);
      end
    end else begin
      if (mem_rd_o) begin
        mem_rdata_lo_i <= lo_m[mem_addr_o];
        mem_rdata_hi_i <= hi_m[mem_addr_o];
      end
      if (mem_wr_o) lo_m[mem_addr_o] <= mem_wdata_lo_o;
    end
  end

  int checks = 0, fails = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic [31:0] exp_lo [128];
  logic [31:0] exp_va [128];
  logic [6:0]  exp_ad [128];
  int          exp_n;

  bit mon_en = 1'b0;
  int busy_cnt, done_cnt, strobe_cnt, seq_err, done_bad;
  bit prev_busy;

  always @(negedge clk) begin
    if (mon_en) begin
      if (busy_o) busy_cnt++;
      if (done_o) begin
        done_cnt++;
        if (busy_o || !prev_busy) done_bad++;
      end
      if (inv_valid_o) begin
        if (strobe_cnt >= exp_n || inv_vaddr_o != exp_va[strobe_cnt]
            || mem_addr_o != exp_ad[strobe_cnt] || !mem_wr_o)
          seq_err++;
        strobe_cnt++;
      end
      prev_busy = busy_o;
    end
  end

  localparam logic [31:0] CASES [5] = '{32'h0000_0011, 32'h0000_0022,
                                        32'hFFFF_FF33, 32'h0000_0044,
                                        32'h0000_3311};

  task automatic run_flush(input logic [31:0] asid, input bit poke, input string tag);
    logic [7:0] id = asid[7:0];
    int wd = 0;
    int bad = 0;
    @(negedge clk); load_req = 1'b1;
    @(negedge clk); load_req = 1'b0;
    exp_n = 0;
    for (int a = 0; a < 128; a++) begin
      exp_lo[a] = gen_lo(a);
      if (exp_lo[a][3] && !exp_lo[a][4] && gen_pid(a) == id) begin
        exp_lo[a][3] = 1'b0;
        exp_va[exp_n] = {gen_hi(a)[31:13], 13'd0};
        exp_ad[exp_n] = 7'(a);
        exp_n++;
      end
    end
    busy_cnt = 0; done_cnt = 0; strobe_cnt = 0; seq_err = 0; done_bad = 0;
    prev_busy = 1'b0;
    mon_en = 1'b1;
    start_i = 1'b1; asid_i = asid;
    @(negedge clk); start_i = 1'b0; asid_i = 32'h0000_0011;
    if (poke) begin
      repeat (40) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
    end
    while (done_cnt == 0 && wd < 1000) begin
      @(negedge clk); wd++;
    end
    repeat (3) @(negedge clk);
    mon_en = 1'b0;
    if (wd >= 1000) check(1'b0, "watchdog", wd, 1000);
    check(busy_cnt == 256, {tag, " R3 busy length"}, busy_cnt, 256);
    check(done_cnt == 1 && done_bad == 0, {tag, " R8 done pulse"}, done_cnt, 1);
    check(seq_err == 0 && strobe_cnt == exp_n, {tag, " R7 strobe sequence"}, strobe_cnt, exp_n);
    for (int a = 0; a < 128; a++) if (lo_m[a] != exp_lo[a]) bad++;
    check(bad == 0, {tag, " R5 R6 entry contents"}, bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy_o && !done_o && !mem_rd_o && !mem_wr_o && !inv_valid_o,
          "R1 reset outputs", {busy_o, done_o, mem_rd_o, mem_wr_o, inv_valid_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !mem_rd_o, "R1 idle after reset", {busy_o, mem_rd_o}, 0);
    // table of cases: R2 upper ID bits ignored in cases 2 and 4
    for (int i = 0; i < 5; i++) run_flush(CASES[i], 1'b0, "R2 table");
    // R9 start during busy ignored
    run_flush(32'h0000_0022, 1'b1, "R9 busy start");
    // R1 quiet after walk
    check(!busy_o && !done_o && !mem_wr_o, "R1 idle after walk", {busy_o, done_o, mem_wr_o}, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    check(1'b0, "watchdog global", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule